// File: doc/BRIEF.md
# Serial Transmit Shifter with Trailing-Bit Masking

This block sends bytes MSB first on a generated serial clock. Software writes a byte into a single-entry transmit buffer. The shifter takes the byte from the buffer when the previous byte finishes. Consecutive bytes therefore form one unbroken stream. Without masking, a stream is always a whole number of bytes.

To send a stream of any length, software clears the hold bit before it writes the final byte. While that byte shifts out, a 4-bit counter counts its shift clocks against a compare value. When the count reaches the compare value, every remaining bit of the byte is forced to 0. The serial clock still completes all eight bit times.

An active-low run input starts and halts shifting. A single interrupt line reports one of two selectable sources: buffer status or end of telegram. A falling edge on either serial pad input also raises this line, so it can act as a wake-up request.

Top module: `ser_mask_tx`

## Requirements
- R1: After reset, `sdo` and `sclk` are 0, `txEmpty` is 1, and `irq` is 0 when `irqEn` and `pinIrqEn` are 0.
- R2: Each byte produces eight bit times of `BIT_CYC` clock cycles each, sent MSB first. In every bit time `sclk` is low for the first `BIT_CYC/2` cycles and high for the rest. `sdo` holds its bit value for the whole bit time.
- R3: A write is accepted only while `txEmpty` is 1, and a write made while it is 0 is dropped. A byte written while the previous byte is still shifting follows it with no gap, so 16 bits span exactly 15 bit times between the first and last `sclk` rising edges.
- R4: A byte written with `holdMask` = 0 is a final word. Only its first `cmpVal` bits appear on `sdo` and the remaining bits are driven to 0. `sclk` still pulses eight times for that byte.
- R5: A final word with `cmpVal` = 0 is sent as eight 0 bits. A final word with `cmpVal` of 8 or more is sent unmasked.
- R6: A byte written with `holdMask` = 1 is never masked, whatever the value of `cmpVal`. The counter and the mask restart for each new byte, so a masked byte leaves no masking on the byte that follows it.
- R7: While `runN` = 1 no shifting happens. Raising `runN` drives `sclk` and `sdo` to 0 by the next cycle and drops the byte in progress, including its mask count. A byte waiting in the buffer is kept and is sent once `runN` returns to 0.
- R8: With `irqSel` = 0, `irq` equals `irqEn` AND (`txEmpty` OR `rxFull`).
- R9: With `irqSel` = 1, `irq` equals `irqEn` AND an end-of-telegram flag. The flag is set when the last bit of a byte completes while the buffer is empty. It is cleared by an accepted write or by `runN` = 1.
- R10: With `pinIrqEn` = 1, a falling edge on `scPin` or `sdPin` makes `irq` high for exactly one cycle, starting the cycle after the edge is sampled. This happens regardless of `irqEn` and `irqSel`. With `pinIrqEn` = 0 such edges have no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runN | input | 1 | Active-low run control; 1 halts and clears the shifter |
| wrEn | input | 1 | Transmit buffer write strobe |
| wrData | input | 8 | Byte to transmit |
| holdMask | input | 1 | 0 marks the written byte as the masked final word |
| cmpVal | input | 4 | Number of unmasked bits in the final word |
| rxFull | input | 1 | Receive-buffer-full status from the receive side |
| irqSel | input | 1 | Interrupt source: 0 buffer status, 1 end of telegram |
| irqEn | input | 1 | Enables the selected interrupt source |
| pinIrqEn | input | 1 | Enables falling-edge interrupts from the pad inputs |
| scPin | input | 1 | Serial clock pad level |
| sdPin | input | 1 | Serial data pad level |
| sclk | output | 1 | Generated shift clock |
| sdo | output | 1 | Serial data out |
| txEmpty | output | 1 | Transmit buffer can accept a byte |
| irq | output | 1 | Interrupt / wake-up request |

## Verification
The assertions check the following on every cycle:
- the mask exists only on a final word;
- the counter stays at zero outside a final word and never passes the word length;
- a full buffer holds its byte until it is loaded;
- a raised `runN` idles the shifter at the next edge;
- the end-of-telegram flag follows its set and clear events.

Only the bench scenarios can show the actual bit stream:
- bit order and contiguity across bytes;
- the exact number of unmasked bits for each compare value, including 0, 8 and above;
- that the mask count does not carry over after an abort;
- that dropped writes never appear on `sdo`.

// File: rtl/ser_mask_pkg.sv
package ser_mask_pkg;
  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic load;   // move buffer into shifter, restart word
    logic shift;  // advance to next bit of current word
    logic clear;  // run control high: drop word, counter, mask
  } shiftCtl_t;
endpackage

// File: rtl/ser_mask_ctrl.sv
module ser_mask_ctrl
  import ser_mask_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int BIT_CYC = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      runN,
  input  logic      bufFull,
  output shiftCtl_t ctl,
  output logic      active,
  output logic      sclk,
  output logic      eotPulse
);
  localparam int PH_W  = (BIT_CYC > 2) ? $clog2(BIT_CYC) : 1;
  localparam int IDX_W = $clog2(WORD_W);
  localparam int HALF  = BIT_CYC / 2;

  logic [PH_W-1:0]  phase;
  logic [IDX_W-1:0] bitIdx;
  logic             bitEnd;
  logic             lastBit;

  assign bitEnd  = active && (phase == PH_W'(BIT_CYC - 1));
  assign lastBit = (bitIdx == IDX_W'(WORD_W - 1));

  always_comb begin
    ctl.clear = runN;
    ctl.load  = !runN && bufFull && (!active || (bitEnd && lastBit));
    ctl.shift = !runN && bitEnd && !lastBit;
  end

  assign eotPulse = !runN && bitEnd && lastBit && !bufFull;
  assign sclk     = active && (phase >= PH_W'(HALF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (ctl.clear) begin
      active <= 1'b0;
      phase  <= '0;
      bitIdx <= '0;
    end else if (ctl.load) begin
      active <= 1'b1;
      phase  <= '0;
      bitIdx <= '0;
    end else if (active) begin
      if (bitEnd) begin
        phase <= '0;
        if (lastBit) active <= 1'b0;
        else         bitIdx <= bitIdx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  // R7: a raised run control leaves the shifter idle after the edge
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    runN |=> !active);

  // R2: within a bit time the word continues and the bit index holds
  a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (active && !bitEnd && !runN) |=> (active && $stable(bitIdx)));
endmodule

// File: rtl/ser_mask_dp.sv
module ser_mask_dp
  import ser_mask_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtl_t         ctl,
  input  logic              active,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              holdMask,
  input  logic [CNT_W-1:0]  cmpVal,
  output logic              bufFull,
  output logic              wrAccept,
  output logic              sdo
);
  logic [WORD_W-1:0] bufReg;
  logic              bufLast;
  logic [WORD_W-1:0] shiftReg;
  logic              curLast;
  logic [CNT_W-1:0]  maskCnt;
  logic              maskOn;
  logic [CNT_W-1:0]  cntNext;

  assign wrAccept = wrEn && !bufFull;
  assign cntNext  = maskCnt + 1'b1;

  // Single-entry transmit buffer; the final-word mark travels with the byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufFull <= 1'b0;
      bufReg  <= '0;
      bufLast <= 1'b0;
    end else if (ctl.load) begin
      bufFull <= 1'b0;
    end else if (wrAccept) begin
      bufFull <= 1'b1;
      bufReg  <= wrData;
      bufLast <= !holdMask;
    end
  end

  // Shifter, MSB leaves first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      curLast  <= 1'b0;
    end else if (ctl.clear) begin
      shiftReg <= '0;
      curLast  <= 1'b0;
    end else if (ctl.load) begin
      shiftReg <= bufReg;
      curLast  <= bufLast;
    end else if (ctl.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  // Shift-clock counter and output mask, live only for the final word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskCnt <= '0;
      maskOn  <= 1'b0;
    end else if (ctl.clear) begin
      maskCnt <= '0;
      maskOn  <= 1'b0;
    end else if (ctl.load) begin
      maskCnt <= '0;
      maskOn  <= bufLast && (cmpVal == '0);
    end else if (ctl.shift && curLast) begin
      maskCnt <= cntNext;
      if (cntNext == cmpVal) maskOn <= 1'b1;
    end
  end

  assign sdo = active && shiftReg[WORD_W-1] && !maskOn;

  // R6: masking only ever applies to a final word
  a_r6_mask_final_only: assert property (@(posedge clk) disable iff (!rstN)
    maskOn |-> curLast);

  // R6: counter stays at rest outside a final word
  a_r6_cnt_idle: assert property (@(posedge clk) disable iff (!rstN)
    !curLast |-> (maskCnt == '0));

  // R4: counter never runs past the word length
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    maskCnt <= CNT_W'(WORD_W));

  // R3: a waiting byte is neither overwritten nor lost until it is loaded
  a_r3_buf_hold: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !ctl.load) |=> (bufFull && $stable(bufReg)));
endmodule

// File: rtl/ser_mask_irq.sv
module ser_mask_irq (
  input  logic clk,
  input  logic rstN,
  input  logic runN,
  input  logic irqSel,
  input  logic irqEn,
  input  logic pinIrqEn,
  input  logic scPin,
  input  logic sdPin,
  input  logic txEmpty,
  input  logic rxFull,
  input  logic eotPulse,
  input  logic wrAccept,
  output logic irq
);
  logic eotFlag;
  logic scPrev, sdPrev;
  logic pinFlag;
  logic srcLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eotFlag <= 1'b0;
    end else if (runN || wrAccept) begin
      eotFlag <= 1'b0;
    end else if (eotPulse) begin
      eotFlag <= 1'b1;
    end
  end

  // Pads idle high; a falling edge gives a one-cycle request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scPrev  <= 1'b1;
      sdPrev  <= 1'b1;
      pinFlag <= 1'b0;
    end else begin
      scPrev  <= scPin;
      sdPrev  <= sdPin;
      pinFlag <= pinIrqEn && ((scPrev && !scPin) || (sdPrev && !sdPin));
    end
  end

  assign srcLevel = irqSel ? eotFlag : (txEmpty || rxFull);
  assign irq      = (irqEn && srcLevel) || pinFlag;

  // R9: end of telegram is recorded unless a write or stop clears it
  a_r9_eot_set: assert property (@(posedge clk) disable iff (!rstN)
    (eotPulse && !wrAccept && !runN) |=> eotFlag);

  // R9: an accepted write clears the end-of-telegram flag
  a_r9_eot_clear: assert property (@(posedge clk) disable iff (!rstN)
    wrAccept |=> !eotFlag);
endmodule

// File: rtl/ser_mask_tx.sv
module ser_mask_tx
  import ser_mask_pkg::*;
#(
  parameter int WORD_W  = 8,
  parameter int BIT_CYC = 4,
  localparam int CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runN,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              holdMask,
  input  logic [CNT_W-1:0]  cmpVal,
  input  logic              rxFull,
  input  logic              irqSel,
  input  logic              irqEn,
  input  logic              pinIrqEn,
  input  logic              scPin,
  input  logic              sdPin,
  output logic              sclk,
  output logic              sdo,
  output logic              txEmpty,
  output logic              irq
);
  shiftCtl_t ctl;
  logic      active;
  logic      bufFull;
  logic      wrAccept;
  logic      eotPulse;

  assign txEmpty = !bufFull;

  ser_mask_ctrl #(.WORD_W(WORD_W), .BIT_CYC(BIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .runN(runN), .bufFull(bufFull),
    .ctl(ctl), .active(active), .sclk(sclk), .eotPulse(eotPulse)
  );

  ser_mask_dp #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .active(active),
    .wrEn(wrEn), .wrData(wrData), .holdMask(holdMask), .cmpVal(cmpVal),
    .bufFull(bufFull), .wrAccept(wrAccept), .sdo(sdo)
  );

  ser_mask_irq u_irq (
    .clk(clk), .rstN(rstN), .runN(runN), .irqSel(irqSel), .irqEn(irqEn),
    .pinIrqEn(pinIrqEn), .scPin(scPin), .sdPin(sdPin), .txEmpty(txEmpty),
    .rxFull(rxFull), .eotPulse(eotPulse), .wrAccept(wrAccept), .irq(irq)
  );
endmodule

// File: tb/ser_mask_tx_tb.sv
module ser_mask_tx_tb;
  localparam int BIT_CYC = 4;

  logic clk = 1'b0;
  logic rstN, runN, wrEn, holdMask, rxFull, irqSel, irqEn, pinIrqEn, scPin, sdPin;
  logic [7:0] wrData;
  logic [3:0] cmpVal;
  logic sclk, sdo, txEmpty, irq;

  int checks = 0;
  int failures = 0;
  int riseCnt = 0;
  int firstRise = 0;
  int lastRise = 0;
  int cyc = 0;
  logic sclkPrev = 1'b0;
  logic expQ[$];
  string curReq = "R2";

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  ser_mask_tx #(.WORD_W(8), .BIT_CYC(BIT_CYC)) u_dut (
    .clk(clk), .rstN(rstN), .runN(runN), .wrEn(wrEn), .wrData(wrData),
    .holdMask(holdMask), .cmpVal(cmpVal), .rxFull(rxFull), .irqSel(irqSel),
    .irqEn(irqEn), .pinIrqEn(pinIrqEn), .scPin(scPin), .sdPin(sdPin),
    .sclk(sclk), .sdo(sdo), .txEmpty(txEmpty), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: writes one byte and pushes its expected serial bits
  task automatic sendWord(input logic [7:0] data, input bit last, input int cmp);
    while (!txEmpty) @(negedge clk);
    for (int i = 0; i < 8; i++)
      expQ.push_back((last && i >= cmp) ? 1'b0 : data[7-i]);
    wrData   = data;
    holdMask = !last;
    wrEn     = 1'b1;
    @(negedge clk);
    wrEn     = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    tick(BIT_CYC + 2);
  endtask

  // Monitor: one expected bit per sclk rising edge
  always @(negedge clk) begin
    if (sclk && !sclkPrev) begin
      riseCnt++;
      if (riseCnt == 1) firstRise = cyc;
      lastRise = cyc;
      if (expQ.size() == 0) begin
        check(1'b0, {curReq, " unexpected bit"}, sdo, -1);
      end else begin
        logic e;
        e = expQ.pop_front();
        check(sdo == e, {curReq, " serial bit"}, sdo, e);
      end
    end
    sclkPrev = sclk;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 0; runN = 1; wrEn = 0; wrData = 0; holdMask = 1; cmpVal = 0;
    rxFull = 0; irqSel = 0; irqEn = 0; pinIrqEn = 0; scPin = 1; sdPin = 1;
    tick(3);
    rstN = 1;
    tick(1);
    // R1 reset state
    check(sdo == 0, "R1 sdo", sdo, 0);
    check(sclk == 0, "R1 sclk", sclk, 0);
    check(txEmpty == 1, "R1 txEmpty", txEmpty, 1);
    check(irq == 0, "R1 irq", irq, 0);

    // R8 buffer-status interrupt, shifter stopped
    irqEn = 1; tick(1);
    check(irq == 1, "R8 empty buffer irq", irq, 1);
    curReq = "R7";
    sendWord(8'h96, 0, 0);
    check(txEmpty == 0, "R3 buffer full", txEmpty, 0);
    check(irq == 0, "R8 full buffer no irq", irq, 0);
    // R3 write while full is dropped
    wrData = 8'h00; wrEn = 1; tick(1); wrEn = 0;
    rxFull = 1; tick(1);
    check(irq == 1, "R8 rxFull irq", irq, 1);
    irqEn = 0; tick(1);
    check(irq == 0, "R8 masked irq", irq, 0);
    rxFull = 0;
    tick(10);
    check(riseCnt == 0, "R7 no shift while stopped", riseCnt, 0);
    runN = 0;
    waitDrain();
    check(riseCnt == 8, "R3 dropped write not sent", riseCnt, 8);

    // R2/R3 contiguous two-byte stream
    curReq = "R2"; riseCnt = 0;
    sendWord(8'hA5, 0, 0);
    sendWord(8'h3C, 0, 0);
    waitDrain();
    check(riseCnt == 16, "R2 sixteen clocks", riseCnt, 16);
    check(lastRise - firstRise == 15 * BIT_CYC, "R3 no gap", lastRise - firstRise, 15 * BIT_CYC);

    // R9 end-of-telegram interrupt
    irqSel = 1; irqEn = 1; tick(1);
    check(irq == 1, "R9 eot irq", irq, 1);
    curReq = "R9";
    sendWord(8'h81, 0, 0);
    check(irq == 0, "R9 cleared by write", irq, 0);
    waitDrain();
    check(irq == 1, "R9 eot after word", irq, 1);
    irqEn = 0;

    // R4 masking of final word
    curReq = "R4";
    cmpVal = 3; sendWord(8'hFF, 1, 3); waitDrain();
    cmpVal = 5; sendWord(8'hB7, 1, 5); waitDrain();

    // R5 boundaries
    curReq = "R5"; riseCnt = 0;
    cmpVal = 0; sendWord(8'hFF, 1, 0); waitDrain();
    check(riseCnt == 8, "R5 full clocks while blanked", riseCnt, 8);
    cmpVal = 9; sendWord(8'h5A, 1, 9); waitDrain();
    cmpVal = 8; sendWord(8'hC3, 1, 8); waitDrain();

    // R6 only final word counts; no carry into next word
    curReq = "R6"; cmpVal = 2;
    sendWord(8'hA5, 0, 2);
    sendWord(8'hC3, 1, 2);
    waitDrain();
    sendWord(8'hF0, 1, 2);
    sendWord(8'hFF, 0, 2);
    waitDrain();

    // R7 abort of a masked word mid-way, then fresh count
    curReq = "R7"; cmpVal = 4; riseCnt = 0;
    sendWord(8'hFF, 1, 4);
    while (riseCnt < 3) @(negedge clk);
    runN = 1;
    expQ.delete();
    tick(1);
    check(sclk == 0, "R7 sclk idle after stop", sclk, 0);
    check(sdo == 0, "R7 sdo low after stop", sdo, 0);
    tick(20);
    check(riseCnt == 3, "R7 word dropped", riseCnt, 3);
    runN = 0;
    sendWord(8'hFF, 1, 4);
    waitDrain();

    // R10 pad falling-edge interrupt
    pinIrqEn = 1; irqEn = 0; tick(1);
    scPin = 0; tick(1);
    check(irq == 1, "R10 sc edge irq", irq, 1);
    tick(1);
    check(irq == 0, "R10 single cycle", irq, 0);
    scPin = 1; tick(1);
    sdPin = 0; tick(1);
    check(irq == 1, "R10 sd edge irq", irq, 1);
    sdPin = 1; pinIrqEn = 0; tick(2);
    sdPin = 0; tick(1);
    check(irq == 0, "R10 disabled edge ignored", irq, 0);
    sdPin = 1; tick(2);

    check(expQ.size() == 0, "R2 queue drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule